// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Selector

This block picks the two source operand values that the decode stage of a five-stage in-order pipeline hands on to execute. Each operand can come from one of three places. The first is the register-file read value. The second is one of five results that later stages have produced but not yet written back. The third applies only to the first operand: the incremented program counter, which call and jump instructions carry down the pipe in the same slot.

Both operands are handled by one lane design, built twice. The first lane has the program-counter merge turned on. The second lane has it turned off. The block is purely combinational: it sits between the register-file read and the decode/execute pipeline register, and it holds no state of its own.

Forwarding sources are ranked so that the newest value wins, in this order:

1. execute ALU result
2. memory-stage load data
3. memory-stage ALU result
4. write-back load data
5. write-back ALU result

Each source is qualified by the destination register ID that travels with it.

Top module: `fwd_operand_sel`

## Requirements
- R1: When the instruction kind is 0x8 (call) or 0x7 (jump), `op_a` equals `d_pc_next`, whatever any forwarding source holds.
- R2: `op_b` never takes `d_pc_next`. For call and jump kinds it is selected exactly as for any other kind.
- R3: When several forwarding sources match, the winner is the highest-ranked one. From highest to lowest the ranking is execute ALU, memory load, memory ALU, write-back load, write-back ALU.
- R4: A source matches only when the operand's source ID equals that source's own destination ID. Load values pair with load destinations and ALU values pair with ALU destinations.
- R5: A source ID of 0xF means "no register" and never forwards. In that case the operand equals its register-file read value, unless R1 applies.
- R6: A destination ID of 0xF disables its source, even when the operand's source ID is also 0xF.
- R7: When no source matches and R1 does not apply, each operand equals its own register-file read value.
- R8: The two lanes are independent. Each lane uses only its own source ID and its own register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_kind | input | 4 | Decoded instruction kind (0x7 jump, 0x8 call) |
| d_src_a | input | 4 | Source register ID for operand A |
| d_src_b | input | 4 | Source register ID for operand B |
| d_pc_next | input | 64 | Incremented program counter |
| d_rf_a | input | 64 | Register-file read value for operand A |
| d_rf_b | input | 64 | Register-file read value for operand B |
| e_dst_alu | input | 4 | Execute-stage ALU destination ID |
| e_alu_val | input | 64 | Execute-stage ALU result |
| m_dst_load | input | 4 | Memory-stage load destination ID |
| m_load_val | input | 64 | Memory-stage read data |
| m_dst_alu | input | 4 | Memory-stage ALU destination ID |
| m_alu_val | input | 64 | Memory-stage ALU result |
| w_dst_load | input | 4 | Write-back load destination ID |
| w_load_val | input | 64 | Write-back load data |
| w_dst_alu | input | 4 | Write-back ALU destination ID |
| w_alu_val | input | 64 | Write-back ALU result |
| op_a | output | 64 | Selected operand A |
| op_b | output | 64 | Selected operand B |

## Verification
The assertions take for granted that every input is a settled, fully defined value when it is evaluated. They also assume the kind and ID codes are exactly those listed in the requirements. The bench drives all inputs together half a cycle away from the sampling point. It never leaves a value undefined.

The sweep covers:
- every source ID, including 0xF;
- every subset of matching sources;
- both call/jump kinds and two other kinds.

Non-matching destinations are always chosen to differ from the source ID. Where a match is wanted, the destination is set equal to it, including the all-ones case that must not match.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NSRC = 5;
  localparam logic [3:0] KIND_JUMP = 4'h7;
  localparam logic [3:0] KIND_CALL = 4'h8;
  // index of each forwarding source, also its rank (0 = highest)
  typedef enum int {
    SRC_E_ALU  = 0,
    SRC_M_LOAD = 1,
    SRC_M_ALU  = 2,
    SRC_W_LOAD = 3,
    SRC_W_ALU  = 4
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int RW = 4
) (
  input  logic [RW-1:0] src_id,
  input  logic [RW-1:0] dst_id,
  output logic          hit
);
  localparam logic [RW-1:0] NONE_ID = '1;

  always_comb begin
    hit = (src_id == dst_id) && (src_id != NONE_ID);
  end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_rank
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end
endmodule

// File: rtl/fwd_lane.sv
module fwd_lane
  import fwd_pkg::*;
#(
  parameter int DW       = 64,
  parameter int RW       = 4,
  parameter bit PC_MERGE = 1'b1
) (
  input  logic [3:0]               kind,
  input  logic [RW-1:0]            src_id,
  input  logic [DW-1:0]            pc_next,
  input  logic [DW-1:0]            rf_val,
  input  logic [NSRC-1:0][RW-1:0]  dst_ids,
  input  logic [NSRC-1:0][DW-1:0]  vals,
  output logic [DW-1:0]            out_val
);
  localparam logic [RW-1:0] NONE_ID = '1;

  logic [NSRC-1:0] hit;
  logic [NSRC-1:0] grant;
  logic            pc_sel;
  logic [DW-1:0]   fwd_val;

  for (genvar i = 0; i < NSRC; i++) begin : g_match
    fwd_match #(.RW(RW)) u_match (
      .src_id (src_id),
      .dst_id (dst_ids[i]),
      .hit    (hit[i])
    );
  end

  fwd_prio #(.N(NSRC)) u_prio (
    .req   (hit),
    .grant (grant)
  );

  if (PC_MERGE) begin : g_pc
    assign pc_sel = (kind == KIND_CALL) || (kind == KIND_JUMP);
  end else begin : g_nopc
    assign pc_sel = 1'b0;
  end

  always_comb begin
    fwd_val = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) fwd_val = fwd_val | vals[i];
    end
  end

  always_comb begin
    if (pc_sel)      out_val = pc_next;
    else if (|grant) out_val = fwd_val;
    else             out_val = rf_val;
  end

  always_comb begin
    if (PC_MERGE && ((kind == KIND_CALL) || (kind == KIND_JUMP)))
      assert_pc_first_R1: assert (out_val == pc_next);
    assert_single_winner_R3: assert ($onehot0(grant));
    assert_grant_on_match_R4: assert ((grant & ~hit) == '0);
    if (!pc_sel && src_id == NONE_ID)
      assert_none_src_R5: assert (out_val == rf_val);
    if (!pc_sel && hit == '0)
      assert_default_rf_R7: assert (out_val == rf_val);
    if (!pc_sel && grant[SRC_E_ALU])
      assert_newest_wins_R3: assert (out_val == vals[SRC_E_ALU]);
  end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int DW = 64,
  parameter int RW = 4
) (
  input  logic [3:0]    d_kind,
  input  logic [RW-1:0] d_src_a,
  input  logic [RW-1:0] d_src_b,
  input  logic [DW-1:0] d_pc_next,
  input  logic [DW-1:0] d_rf_a,
  input  logic [DW-1:0] d_rf_b,
  input  logic [RW-1:0] e_dst_alu,
  input  logic [DW-1:0] e_alu_val,
  input  logic [RW-1:0] m_dst_load,
  input  logic [DW-1:0] m_load_val,
  input  logic [RW-1:0] m_dst_alu,
  input  logic [DW-1:0] m_alu_val,
  input  logic [RW-1:0] w_dst_load,
  input  logic [DW-1:0] w_load_val,
  input  logic [RW-1:0] w_dst_alu,
  input  logic [DW-1:0] w_alu_val,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b
);
  logic [NSRC-1:0][RW-1:0] dst_ids;
  logic [NSRC-1:0][DW-1:0] vals;

  assign dst_ids[SRC_E_ALU]  = e_dst_alu;
  assign dst_ids[SRC_M_LOAD] = m_dst_load;
  assign dst_ids[SRC_M_ALU]  = m_dst_alu;
  assign dst_ids[SRC_W_LOAD] = w_dst_load;
  assign dst_ids[SRC_W_ALU]  = w_dst_alu;
  assign vals[SRC_E_ALU]     = e_alu_val;
  assign vals[SRC_M_LOAD]    = m_load_val;
  assign vals[SRC_M_ALU]     = m_alu_val;
  assign vals[SRC_W_LOAD]    = w_load_val;
  assign vals[SRC_W_ALU]     = w_alu_val;

  fwd_lane #(.DW(DW), .RW(RW), .PC_MERGE(1'b1)) u_lane_a (
    .kind    (d_kind),
    .src_id  (d_src_a),
    .pc_next (d_pc_next),
    .rf_val  (d_rf_a),
    .dst_ids (dst_ids),
    .vals    (vals),
    .out_val (op_a)
  );

  fwd_lane #(.DW(DW), .RW(RW), .PC_MERGE(1'b0)) u_lane_b (
    .kind    (d_kind),
    .src_id  (d_src_b),
    .pc_next (d_pc_next),
    .rf_val  (d_rf_b),
    .dst_ids (dst_ids),
    .vals    (vals),
    .out_val (op_b)
  );

  always_comb begin
    if (d_src_a == d_src_b && d_rf_a == d_rf_b &&
        !(d_kind == KIND_CALL || d_kind == KIND_JUMP))
      assert_lanes_agree_R8: assert (op_a == op_b);
  end
endmodule

// File: tb/sim_fwd_operand_sel.sv
`timescale 1ns/1ps
module sim_fwd_operand_sel;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  d_kind, d_src_a, d_src_b;
  logic [63:0] d_pc_next, d_rf_a, d_rf_b;
  logic [3:0]  dst [5];
  logic [63:0] val [5];
  logic [63:0] op_a, op_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fwd_operand_sel u0 (
    .d_kind(d_kind), .d_src_a(d_src_a), .d_src_b(d_src_b),
    .d_pc_next(d_pc_next), .d_rf_a(d_rf_a), .d_rf_b(d_rf_b),
    .e_dst_alu(dst[0]),  .e_alu_val(val[0]),
    .m_dst_load(dst[1]), .m_load_val(val[1]),
    .m_dst_alu(dst[2]),  .m_alu_val(val[2]),
    .w_dst_load(dst[3]), .w_load_val(val[3]),
    .w_dst_alu(dst[4]),  .w_alu_val(val[4]),
    .op_a(op_a), .op_b(op_b)
  );

  function automatic logic [63:0] expect_op(input bit merge, input logic [3:0] kind,
                                            input logic [3:0] src, input logic [63:0] rf);
    if (merge && (kind == 4'h8 || kind == 4'h7)) return d_pc_next;
    if (src != 4'hF)
      for (int i = 0; i < 5; i++)
        if (dst[i] == src) return val[i];
    return rf;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    d_kind = 4'h0; d_src_a = 4'hF; d_src_b = 4'hF;
    d_pc_next = 64'h0; d_rf_a = 64'h0; d_rf_b = 64'h0;
    for (int i = 0; i < 5; i++) begin dst[i] = 4'hF; val[i] = 64'h0; end
    @(negedge clk);
    d_rf_a = 64'hAAAA_0000_0000_0001; d_rf_b = 64'hBBBB_0000_0000_0002;
    #2;
    check("R6 all dests none", op_a, d_rf_a);
    check("R5 src none", op_b, d_rf_b);

    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 16; s++) begin
        for (int m = 0; m < 32; m++) begin
          @(negedge clk);
          d_kind = (k == 0) ? 4'h8 : (k == 1) ? 4'h7 : (k == 2) ? 4'h2 : 4'h6;
          d_src_a = 4'(s);
          d_src_b = 4'(15 - s);
          d_pc_next = {32'hC0DE_0000, 16'(s), 16'(m)};
          d_rf_a = {32'hA000_0000, 16'(s), 16'(m)};
          d_rf_b = {32'hB000_0000, 16'(s), 16'(m)};
          for (int i = 0; i < 5; i++) begin
            dst[i] = m[i] ? 4'(s) : (4'(s) ^ 4'(i + 1));
            val[i] = {8'(i + 1), 24'h0, 16'(s), 16'(m)};
          end
          #2;
          if (k < 2) check("R1 pc merge for call/jump", op_a, expect_op(1'b1, d_kind, d_src_a, d_rf_a));
          else if (s == 15) check("R5/R6 none id never forwards", op_a, expect_op(1'b1, d_kind, d_src_a, d_rf_a));
          else if (m == 0) check("R7 default rf", op_a, expect_op(1'b1, d_kind, d_src_a, d_rf_a));
          else check("R3/R4 ranked forwarding", op_a, expect_op(1'b1, d_kind, d_src_a, d_rf_a));
          check("R2/R8 op_b lane", op_b, expect_op(1'b0, d_kind, d_src_b, d_rf_b));
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule